// File: doc/BRIEF.md
# Handshake Parallel Port Controller

This block is a byte-wide bidirectional port that lets an external host trade bytes with a local CPU. The host writes into an input buffer with an input strobe and reads from an output buffer while it holds an output strobe low. Two flags track the buffers. Input-full is set when the host has loaded a byte and is cleared when the CPU reads it. Output-full is set when the CPU writes a byte and is cleared by the host's output strobe. Each flag raises a one-clock interrupt pulse when it reaches the state that needs the CPU.

A control/status byte chooses the strobe edges and the input latching style. It also sets the function of two flag pins. Each pin can drive a constant, show a buffer flag, or act as an input. The A pin as an input selects whether the port shows the output data or the control/status byte. The B pin as an input is a port enable, so several ports can share one host bus.

The CPU side is a synchronous register bus. A read of register 0 returns the input buffer and clears input-full, and a write to register 0 loads the output buffer. Register 1 holds the control/status byte. Register 2 returns, in bit 0, the A pin level captured at the most recent host load. The strobe and flag inputs go through synchronizers before they reach any state. The driver enable and the data source select act straight from the pins.

Top module: `hsk_pport`

## Requirements
- R1: After reset, register 1 reads 0xFC, both interrupt outputs are low, neither flag pin is driven, and the data drivers are off while the output strobe is high.
- R2: In register 1, bits 7..2 are read/write with layout {B mode[7:6], A mode[5:4], output clear edge[3], input style[2]}. Bits 1 (output-full) and 0 (input-full) ignore CPU writes.
- R3: With bit 2 = 0, the rising edge of the input strobe loads pin_din into the input buffer and sets input-full. Later changes on pin_din do not alter the buffer.
- R4: With bit 2 = 1, the input buffer follows pin_din while the synchronized strobe is low, holds once it is high, and input-full is set on the falling edge.
- R5: A CPU read of register 0 clears input-full. A CPU write of register 0 loads the output buffer and sets output-full.
- R6: With bit 3 = 1, a rising edge of the output strobe clears output-full. With bit 3 = 0, a falling edge clears it.
- R7: pin_doe is high exactly while ods_n is low and the port is not disabled by R11.
- R8: A pin mode 00 drives 0, 01 drives 1, 10 drives output-full, and 11 releases the pin (aflag_oe low).
- R9: In A mode 11, aflag_in = 0 puts the output buffer on pin_dout, and aflag_in = 1 puts the register 1 value there.
- R10: Each event that sets input-full also stores the synchronized A pin level in register 2 bit 0.
- R11: B pin mode 00 drives 0, 01 drives 1, and 10 drives input-full. Mode 11 releases the pin and makes it a port enable: while bflag_in is high the data drivers stay off and both strobes' edges are ignored.
- R12: irq_in pulses for one clock when input-full goes from 0 to 1. irq_out pulses for one clock when output-full goes from 1 to 0.
- R13: When a strobe event and a CPU access of register 0 fall in the same cycle, the strobe event sets the flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control/status, 2 captured A level |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on register 0) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| pin_din | input | DW | Host data into the port |
| pin_dout | output | DW | Port data toward the host |
| pin_doe | output | 1 | Port data driver enable |
| ids_n | input | 1 | Host input strobe |
| ods_n | input | 1 | Host output strobe, active low |
| aflag_in | input | 1 | A flag pin input level |
| aflag_out | output | 1 | A flag pin drive value |
| aflag_oe | output | 1 | A flag pin drive enable |
| bflag_in | input | 1 | B flag pin input level |
| bflag_out | output | 1 | B flag pin drive value |
| bflag_oe | output | 1 | B flag pin drive enable |
| irq_in | output | 1 | Input-full interrupt pulse |
| irq_out | output | 1 | Output-empty interrupt pulse |

## Verification
A level change on a strobe or flag input takes effect on the third rising clock edge after it. Two edges pass through the synchronizer and the third registers the flag, buffer or interrupt. The bench drives each pin on a falling edge and waits three falling edges before it samples, and it checks each interrupt pulse on that same falling edge and again one clock later. A CPU access takes effect one edge after it is driven. The driver enable and the data source select follow the pins combinationally and are sampled one nanosecond after the drive. The same-cycle tests place the CPU access in the cycle that ends on that third edge.

// File: rtl/hsk_pport_pkg.sv
// Shared types for the handshake parallel port.
// Assumes an 8-bit control/status layout whose upper six bits are the ctrl_t fields.
package hsk_pport_pkg;

    // Function of one flag pin
    typedef enum logic [1:0] {
        PIN_LO   = 2'b00,
        PIN_HI   = 2'b01,
        PIN_FLAG = 2'b10,
        PIN_IN   = 2'b11
    } pin_mode_e;

    // Writable control bits, packed in register order (bit 7 down to bit 2)
    typedef struct packed {
        pin_mode_e bmode;
        pin_mode_e amode;
        logic      oclr_rise;
        logic      in_transp;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = 6'b111111;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_AUX  = 2'd2;

endpackage

// File: rtl/hsk_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
// Assumes each bit is independent; RST_VAL is the idle level of each bit.
module hsk_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hsk_edge.sv
// Edge detector for synchronized levels; one-cycle rise and fall indications.
// Assumes the inputs are already in the clk domain.
module hsk_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/hsk_flagpin.sv
// Drive logic for one configurable flag pin.
// Assumes the input function of the pin is handled by the parent.
module hsk_flagpin
    import hsk_pport_pkg::*;
(
    input  pin_mode_e mode,
    input  logic      flag,
    output logic      drv,
    output logic      oe
);
    // Select the driven level for the current mode
    always_comb begin
        case (mode)
            PIN_LO:   drv = 1'b0;
            PIN_HI:   drv = 1'b1;
            PIN_FLAG: drv = flag;
            default:  drv = 1'b0;
        endcase
        oe = (mode != PIN_IN);
    end
endmodule

// File: rtl/hsk_pport.sv
// Handshake parallel port: host-strobed input buffer, CPU-loaded output buffer,
// full flags with interrupt pulses, and two configurable flag pins.
// Assumes pin_din is stable around the input strobe edges; strobes and flag
// inputs are synchronized; driver enable and source select act from raw pins.
module hsk_pport
    import hsk_pport_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pin_din,
    output logic [DW-1:0] pin_dout,
    output logic          pin_doe,
    input  logic          ids_n,
    input  logic          ods_n,
    input  logic          aflag_in,
    output logic          aflag_out,
    output logic          aflag_oe,
    input  logic          bflag_in,
    output logic          bflag_out,
    output logic          bflag_oe,
    output logic          irq_in,
    output logic          irq_out
);
    localparam int CSR_W = 8;
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] sync_q;
    logic [1:0]       stb_rise, stb_fall;
    logic             ids_s, ods_s, af_s, bf_s;
    ctrl_t            ctrl;
    logic             ibf, obf, af_lat;
    logic [DW-1:0]    ibuf, obuf;
    logic [CSR_W-1:0] csr;
    logic             port_off_s, port_off_p;
    logic             load_evt, oclr_evt, rd_data, wr_data, wr_ctrl;

    hsk_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bflag_in, aflag_in, ods_n, ids_n}),
        .q(sync_q)
    );
    assign {bf_s, af_s, ods_s, ids_s} = sync_q;

    hsk_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl({ods_s, ids_s}),
        .rise(stb_rise), .fall(stb_fall)
    );

    // Decode port gating, strobe events and CPU accesses
    always_comb begin
        port_off_s = (ctrl.bmode == PIN_IN) && bf_s;
        port_off_p = (ctrl.bmode == PIN_IN) && bflag_in;
        load_evt   = !port_off_s && (ctrl.in_transp ? stb_fall[0] : stb_rise[0]);
        oclr_evt   = !port_off_s && (ctrl.oclr_rise ? stb_rise[1] : stb_fall[1]);
        rd_data    = bus_rd && (bus_addr == REG_DATA);
        wr_data    = bus_wr && (bus_addr == REG_DATA);
        wr_ctrl    = bus_wr && (bus_addr == REG_CTRL);
    end

    assign csr = {ctrl, obf, ibf};

    // Control bits: written by the CPU, read-only flags excluded
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= CTRL_RST;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CSR_W-1:2]);
    end

    // Input buffer: edge capture or transparent follow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibuf <= '0;
        end else if (!port_off_s) begin
            if (ctrl.in_transp ? !ids_s : stb_rise[0]) ibuf <= pin_din;
        end
    end

    // Input-full flag, captured A level and input interrupt; strobe wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf    <= 1'b0;
            af_lat <= 1'b0;
            irq_in <= 1'b0;
        end else begin
            irq_in <= load_evt && !ibf;
            if (load_evt) begin
                ibf    <= 1'b1;
                af_lat <= af_s;
            end else if (rd_data) begin
                ibf    <= 1'b0;
            end
        end
    end

    // Output buffer, output-full flag and output interrupt; strobe wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obuf    <= '0;
            obf     <= 1'b0;
            irq_out <= 1'b0;
        end else begin
            irq_out <= oclr_evt && obf;
            if (wr_data) obuf <= bus_wdata;
            if (oclr_evt)     obf <= 1'b0;
            else if (wr_data) obf <= 1'b1;
        end
    end

    // CPU read mux
    always_comb begin
        case (bus_addr)
            REG_DATA: bus_rdata = ibuf;
            REG_CTRL: bus_rdata = DW'(csr);
            REG_AUX:  bus_rdata = DW'(af_lat);
            default:  bus_rdata = '0;
        endcase
    end

    // Host-side data source and driver enable
    always_comb begin
        pin_dout = ((ctrl.amode == PIN_IN) && aflag_in) ? DW'(csr) : obuf;
        pin_doe  = !ods_n && !port_off_p;
    end

    hsk_flagpin u_apin (.mode(ctrl.amode), .flag(obf), .drv(aflag_out), .oe(aflag_oe));
    hsk_flagpin u_bpin (.mode(ctrl.bmode), .flag(ibf), .drv(bflag_out), .oe(bflag_oe));
endmodule

// File: rtl/hsk_pport_chk.sv
// Property checker for the handshake parallel port, bound into every instance.
// Assumes synchronous active-low reset on clk.
module hsk_pport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ibf,
    input logic       obf,
    input logic       irq_in,
    input logic       irq_out,
    input logic       pin_doe,
    input logic       ods_n,
    input logic       bflag_in,
    input logic [1:0] bmode
);
    // R12
    ibf_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> irq_in);
    // R12
    irq_in_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |-> ibf);
    // R12
    irq_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |=> !irq_in);
    // R12
    obf_fall_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obf) |-> irq_out);
    // R6
    irq_out_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> !obf);
    // R7
    doe_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_doe |-> !ods_n);
    // R11
    port_off_doe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bmode == 2'b11 && bflag_in) |-> !pin_doe);
endmodule

bind hsk_pport hsk_pport_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ibf(ibf), .obf(obf),
    .irq_in(irq_in), .irq_out(irq_out), .pin_doe(pin_doe),
    .ods_n(ods_n), .bflag_in(bflag_in), .bmode(ctrl.bmode)
);

// File: tb/tb_hsk_pport.sv
// Self-checking bench for hsk_pport; drives on falling edges, samples away from rising edges.
module tb_hsk_pport;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic [DW-1:0] pin_din = '0, pin_dout;
    logic          pin_doe, ids_n = 1'b1, ods_n = 1'b1;
    logic          aflag_in = 1'b0, aflag_out, aflag_oe;
    logic          bflag_in = 1'b0, bflag_out, bflag_oe;
    logic          irq_in, irq_out;

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    hsk_pport #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_din(pin_din), .pin_dout(pin_dout),
        .pin_doe(pin_doe), .ids_n(ids_n), .ods_n(ods_n), .aflag_in(aflag_in),
        .aflag_out(aflag_out), .aflag_oe(aflag_oe), .bflag_in(bflag_in),
        .bflag_out(bflag_out), .bflag_oe(bflag_oe), .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_wr(input logic [1:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cpu_rd(input logic [1:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output int v);
        bus_addr = a; #1; v = int'(bus_rdata);
    endtask

    // Host loads a byte: strobe low, then high, then wait for the synchronizer
    task automatic host_load();
        ids_n = 1'b0; waitn(3);
        ids_n = 1'b1; waitn(3);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0x1 expected 0x0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int v;
        logic [7:0] pats [5] = '{8'h00, 8'h5A, 8'hA5, 8'hFF, 8'h3C};
        waitn(3);
        rst_n = 1'b1;
        waitn(1);

        // R1 reset state
        peek(2'd1, v); check("R1 csr", v, 8'hFC);
        check("R1 irq_in", int'(irq_in), 0);
        check("R1 irq_out", int'(irq_out), 0);
        check("R1 aflag_oe", int'(aflag_oe), 0);
        check("R1 bflag_oe", int'(bflag_oe), 0);
        check("R1 pin_doe", int'(pin_doe), 0);

        // R2 sweep of writable bits; low bits written as ones must read zero
        for (int k = 0; k < 64; k++) begin
            cpu_wr(2'd1, 8'((k << 2) | 3));
            peek(2'd1, v); check("R2 csr rw", v, (k << 2));
        end

        // R3 edge capture; B pin shows input-full, A pin shows output-full
        cpu_wr(2'd1, 8'hA8);
        for (int p = 0; p < 5; p++) begin
            pin_din  = pats[p];
            aflag_in = pats[p][0];
            ids_n = 1'b0; waitn(3);
            peek(2'd1, v); check("R3 no set on fall", v & 1, 0);
            ids_n = 1'b1; waitn(3);
            peek(2'd1, v); check("R3 ibf set", v & 1, 1);
            check("R11 bflag shows ibf", int'(bflag_out), 1);
            check("R12 irq_in pulse", int'(irq_in), 1);
            pin_din = ~pats[p];
            waitn(1);
            check("R12 irq_in one clock", int'(irq_in), 0);
            waitn(1);
            peek(2'd0, v); check("R3 buffer held", v, int'(pats[p]));
            peek(2'd2, v); check("R10 A level latched", v, int'(pats[p][0]));
            cpu_rd(2'd0);
            peek(2'd1, v); check("R5 read clears ibf", v & 1, 0);
            check("R11 bflag follows", int'(bflag_out), 0);
        end
        aflag_in = 1'b0;

        // R4 transparent input
        cpu_wr(2'd1, 8'hAC);
        pin_din = 8'h11;
        ids_n = 1'b0; waitn(3);
        peek(2'd1, v); check("R4 ibf on fall", v & 1, 1);
        peek(2'd0, v); check("R4 follows", v, 8'h11);
        pin_din = 8'h22; waitn(1);
        peek(2'd0, v); check("R4 follows new", v, 8'h22);
        ids_n = 1'b1; waitn(3);
        pin_din = 8'h33; waitn(2);
        peek(2'd0, v); check("R4 holds", v, 8'h22);
        cpu_rd(2'd0);
        peek(2'd1, v); check("R5 clear", v & 1, 0);

        // R5 R6 output side, clear on rising edge
        cpu_wr(2'd1, 8'hA8);
        cpu_wr(2'd0, 8'h96);
        peek(2'd1, v); check("R5 obf set", (v >> 1) & 1, 1);
        check("R8 aflag shows obf", int'(aflag_out), 1);
        ods_n = 1'b0; #1;
        check("R7 doe on", int'(pin_doe), 1);
        check("R7 dout", int'(pin_dout), 8'h96);
        waitn(3);
        peek(2'd1, v); check("R6 fall ignored", (v >> 1) & 1, 1);
        ods_n = 1'b1; #1;
        check("R7 doe off", int'(pin_doe), 0);
        waitn(3);
        peek(2'd1, v); check("R6 rise clears", (v >> 1) & 1, 0);
        check("R12 irq_out pulse", int'(irq_out), 1);
        waitn(1);
        check("R12 irq_out one clock", int'(irq_out), 0);
        // R6 clear on falling edge
        cpu_wr(2'd1, 8'hA0);
        cpu_wr(2'd0, 8'h69);
        ods_n = 1'b0; waitn(3);
        peek(2'd1, v); check("R6 fall clears", (v >> 1) & 1, 0);
        check("R12 irq_out fall mode", int'(irq_out), 1);
        ods_n = 1'b1; waitn(3);

        // R8 R11 constant pin modes
        cpu_wr(2'd1, 8'h08); #1;
        check("R8 A lo", int'({aflag_oe, aflag_out}), 2);
        check("R11 B lo", int'({bflag_oe, bflag_out}), 2);
        cpu_wr(2'd1, 8'h58); #1;
        check("R8 A hi", int'({aflag_oe, aflag_out}), 3);
        check("R11 B hi", int'({bflag_oe, bflag_out}), 3);

        // R9 source select
        cpu_wr(2'd1, 8'h38);
        aflag_in = 1'b1; #1;
        check("R8 A released", int'(aflag_oe), 0);
        check("R9 csr on port", int'(pin_dout), 8'h38);
        aflag_in = 1'b0; #1;
        check("R9 data on port", int'(pin_dout), 8'h69);
        waitn(3);

        // R11 port enable input
        cpu_wr(2'd1, 8'hC8);
        bflag_in = 1'b1; waitn(3);
        check("R11 B released", int'(bflag_oe), 0);
        cpu_wr(2'd0, 8'h5C);
        ods_n = 1'b0; #1;
        check("R11 doe gated", int'(pin_doe), 0);
        waitn(3);
        ods_n = 1'b1; waitn(3);
        peek(2'd1, v); check("R11 ods ignored", (v >> 1) & 1, 1);
        pin_din = 8'h77;
        host_load();
        peek(2'd1, v); check("R11 ids ignored", v & 1, 0);
        peek(2'd0, v); check("R11 buffer kept", v, 8'h22);
        bflag_in = 1'b0; waitn(3);
        ods_n = 1'b0; #1;
        check("R7 doe enabled", int'(pin_doe), 1);
        waitn(3);
        ods_n = 1'b1; waitn(3);
        peek(2'd1, v); check("R11 ods active", (v >> 1) & 1, 0);
        host_load();
        peek(2'd1, v); check("R11 ids active", v & 1, 1);
        peek(2'd0, v); check("R11 loaded", v, 8'h77);

        // R13 strobe load against CPU read in the same cycle, ibf already set
        cpu_wr(2'd1, 8'h08);
        pin_din = 8'h4D;
        ids_n = 1'b0; waitn(3);
        ids_n = 1'b1; waitn(2);
        cpu_rd(2'd0);
        peek(2'd1, v); check("R13 load beats read", v & 1, 1);
        check("R12 no irq_in when already full", int'(irq_in), 0);
        peek(2'd0, v); check("R13 buffer", v, 8'h4D);
        // R13 output clear against CPU write in the same cycle
        cpu_wr(2'd0, 8'h12);
        ods_n = 1'b0; waitn(3);
        ods_n = 1'b1; waitn(2);
        cpu_wr(2'd0, 8'h44);
        peek(2'd1, v); check("R13 clear beats write", (v >> 1) & 1, 0);
        check("R13 irq_out", int'(irq_out), 1);
        ods_n = 1'b0; #1;
        check("R13 buffer written", int'(pin_dout), 8'h44);
        ods_n = 1'b1;
        waitn(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule